// File: doc/BRIEF.md
# Multidrop Backplane Slot Selector

This block lets one board on a shared IEEE 1149.1 backplane decide whether the test master is talking to it. It runs its own TAP controller on the backplane TCK, TMS and TDI lines and holds an 8-bit instruction register. Each time the controller passes through Update-IR, the shifted value is compared with the board's hard-wired slot pins and with a small set of reserved codes. The result is a persistent selection state: unique, group, broadcast, interrogated or none.

Only a uniquely selected board enables the backplane TDO driver, and only during Shift-IR or Shift-DR. Broadcast and group selections keep TDO off, so several boards never drive it together. An interrogation code makes the next Capture-IR load the slot pins, so the shifted-out value carries the board's address on the internal `tdo` data line. A selected board also accepts two park codes that hold the local scan chains in Run-Test/Idle or in Pause by forcing the local TMS low while the backplane continues.

Code map for the default 8-bit width: 8'h00 is reserved, 8'h01 to 8'hF7 are unique slots, 8'hF8 to 8'hFB are groups 0 to 3, 8'hFC parks in Run-Test/Idle, 8'hFD parks in Pause, 8'hFE interrogates, and 8'hFF broadcasts.

Top module: `mdrop_slot_sel`

## Requirements
- R1: While `trst_n` is low and after it is released, `selected`, `shared_sel`, `tdo_oe`, `park_rti` and `park_pause` are all 0.
- R2: An Update-IR with a code from 8'h01 to 8'hF7 that equals `slot_addr` sets `selected`=1 and `shared_sel`=0 from the TCK rising edge that leaves Update-IR.
- R3: An Update-IR with any non-park code that selects nothing clears a previous selection.
- R4: The code 8'h00 never selects the board, even when `slot_addr` is 8'h00.
- R5: The code 8'hFF selects every board with `selected`=1 and `shared_sel`=1.
- R6: The code 8'hF8+g (g from 0 to 3) selects the board with `selected`=1 and `shared_sel`=1 only when `grp_en[g]` is 1, and selects nothing otherwise.
- R7: `tdo_oe` is 1 only while the board is uniquely selected and the TAP is in Shift-IR or Shift-DR. Both `tdo` and `tdo_oe` change on the falling TCK edge. In Shift-DR, `tdo` is a one-bit bypass whose first bit is 0.
- R8: The instruction register shifts LSB first, with TDI entering at the MSB. Capture-IR loads `slot_addr` when the last decoded code was 8'hFE, and loads 8'h01 otherwise. The code 8'hFE leaves `selected`=0 and `shared_sel`=0.
- R9: On a selected board, 8'hFC sets `park_rti` and 8'hFD sets `park_pause`. Either one leaves the selection unchanged and forces `lcl_tms` to 0. Any later non-park Update-IR clears the park.
- R10: Park codes have no effect on a board that is not selected.
- R11: Selection and park state change only at an Update-IR or on entry to Test-Logic-Reset. Data-register scans leave them unchanged.
- R12: Entering Test-Logic-Reset, whether through `trst_n` or through five TCK cycles with TMS high, clears the selection and the park.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Backplane test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Backplane mode select |
| tdi | input | 1 | Backplane serial data in |
| slot_addr | input | 8 | Static slot address pins |
| grp_en | input | 4 | Group membership, one bit per group |
| tdo | output | 1 | Serial data toward the backplane TDO driver |
| tdo_oe | output | 1 | Output enable for the backplane TDO driver |
| selected | output | 1 | Board selected (unique, group or broadcast) |
| shared_sel | output | 1 | Selection is group or broadcast |
| park_rti | output | 1 | Local chains parked in Run-Test/Idle |
| park_pause | output | 1 | Local chains parked in Pause |
| lcl_tms | output | 1 | TMS toward the local scan chains |

## Verification
A wrong selection state shows at `selected` and `shared_sel` one TCK edge after Update-IR, and at `tdo_oe` in the very next shift state. A TAP controller that has lost step shows up within one scan: the shifted-out capture value (8'h01 or the slot pins) arrives misaligned or missing, or the bypass bit is absent. A stale park shows at `lcl_tms` as soon as TMS is driven high. A selection that survives a reset shows within five TMS-high cycles.

// File: rtl/mdss_pkg.sv
package mdss_pkg;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_state_e;

   typedef enum logic [2:0] {
      SK_NONE, SK_UNIQUE, SK_GROUP, SK_BCAST, SK_INTERROG
   } sel_kind_e;

   typedef enum logic [1:0] {
      PK_NONE, PK_IDLE, PK_PAUSE
   } park_e;

   function automatic tap_state_e tap_step(input tap_state_e s, input logic m);
      tap_state_e n;
      case (s)
         TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
         TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
         TS_SHF_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
         TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: n = m ? TS_UPD_DR : TS_SHF_DR;
         TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
         TS_SHF_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
         TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: n = m ? TS_UPD_IR : TS_SHF_IR;
         TS_UPD_IR: n = m ? TS_SEL_DR : TS_IDLE;
         default:   n = TS_RESET;
      endcase
      return n;
   endfunction

   function automatic logic sel_is_active(input sel_kind_e k);
      return (k == SK_UNIQUE) || (k == SK_GROUP) || (k == SK_BCAST);
   endfunction

endpackage

// File: rtl/mdss_tap.sv
module mdss_tap
   import mdss_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state,
   output tap_state_e nxt
);

   assign nxt = tap_step(state, tms);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         state <= TS_RESET;
      end else begin
         state <= nxt;
      end
   end

endmodule

// File: rtl/mdss_ir.sv
module mdss_ir
   import mdss_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             tck,
   input  logic             trst_n,
   input  tap_state_e       state,
   input  logic             tdi,
   input  logic [WIDTH-1:0] cap_val,
   output logic [WIDTH-1:0] sh
);

   localparam logic [WIDTH-1:0] RST_VAL = WIDTH'(1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("mdss_ir: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sh <= RST_VAL;
      end else begin
         case (state)
            TS_CAP_IR: sh <= cap_val;
            TS_SHF_IR: sh <= {tdi, sh[WIDTH-1:1]};
            TS_RESET:  sh <= RST_VAL;
            default:   sh <= sh;
         endcase
      end
   end

endmodule

// File: rtl/mdss_decode.sv
module mdss_decode
   import mdss_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned NUM_GROUPS = 4
) (
   input  logic [ADDR_W-1:0]     code,
   input  logic [ADDR_W-1:0]     slot_addr,
   input  logic [NUM_GROUPS-1:0] grp_en,
   output sel_kind_e             kind,
   output park_e                 park
);

   localparam int unsigned ALL_ONES     = (1 << ADDR_W) - 1;
   localparam int unsigned PARK_RTI_I   = ALL_ONES - 3;
   localparam int unsigned GROUP_BASE_I = PARK_RTI_I - NUM_GROUPS;

   localparam logic [ADDR_W-1:0] C_BCAST      = ADDR_W'(ALL_ONES);
   localparam logic [ADDR_W-1:0] C_INTERROG   = ADDR_W'(ALL_ONES - 1);
   localparam logic [ADDR_W-1:0] C_PARK_PAUSE = ADDR_W'(ALL_ONES - 2);
   localparam logic [ADDR_W-1:0] C_PARK_RTI   = ADDR_W'(PARK_RTI_I);
   localparam logic [ADDR_W-1:0] C_GROUP_BASE = ADDR_W'(GROUP_BASE_I);

   generate
      if (ADDR_W < 4 || ADDR_W > 16) begin : g_bad_addr_w
         $error("mdss_decode: ADDR_W must lie between 4 and 16");
      end
      if (NUM_GROUPS < 1 || GROUP_BASE_I < 2) begin : g_bad_groups
         $error("mdss_decode: group codes leave no room for unique slots");
      end
   endgenerate

   logic [NUM_GROUPS-1:0] grp_hit;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam logic [ADDR_W-1:0] GCODE = ADDR_W'(GROUP_BASE_I + g);
      assign grp_hit[g] = grp_en[g] && (code == GCODE);
   end

   logic uniq_ok;
   assign uniq_ok = (code != '0) && (code < C_GROUP_BASE) && (code == slot_addr);

   always_comb begin
      if (code == C_BCAST) begin
         kind = SK_BCAST;
      end else if (code == C_INTERROG) begin
         kind = SK_INTERROG;
      end else if (|grp_hit) begin
         kind = SK_GROUP;
      end else if (uniq_ok) begin
         kind = SK_UNIQUE;
      end else begin
         kind = SK_NONE;
      end
   end

   always_comb begin
      if (code == C_PARK_RTI) begin
         park = PK_IDLE;
      end else if (code == C_PARK_PAUSE) begin
         park = PK_PAUSE;
      end else begin
         park = PK_NONE;
      end
   end

endmodule

// File: rtl/mdrop_slot_sel.sv
module mdrop_slot_sel
   import mdss_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned NUM_GROUPS = 4,
   parameter bit          TDO_RETIME = 1'b1
) (
   input  logic                  tck,
   input  logic                  trst_n,
   input  logic                  tms,
   input  logic                  tdi,
   input  logic [ADDR_W-1:0]     slot_addr,
   input  logic [NUM_GROUPS-1:0] grp_en,
   output logic                  tdo,
   output logic                  tdo_oe,
   output logic                  selected,
   output logic                  shared_sel,
   output logic                  park_rti,
   output logic                  park_pause,
   output logic                  lcl_tms
);

   localparam logic [ADDR_W-1:0] IDCODE_CAP = ADDR_W'(1);

   tap_state_e        tap_st;
   tap_state_e        tap_nx;
   logic [ADDR_W-1:0] ir_sh;
   logic [ADDR_W-1:0] cap_val;
   sel_kind_e         kind_q;
   sel_kind_e         dec_kind;
   park_e             park_q;
   park_e             dec_park;
   logic              byp_q;
   logic              sel_any;
   logic              sel_uniq;
   logic              shift_any;
   logic              tdo_d;
   logic              oe_d;

   mdss_tap u_tap (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (tap_st),
      .nxt    (tap_nx)
   );

   assign cap_val = (kind_q == SK_INTERROG) ? slot_addr : IDCODE_CAP;

   mdss_ir #(.WIDTH(ADDR_W)) u_ir (
      .tck     (tck),
      .trst_n  (trst_n),
      .state   (tap_st),
      .tdi     (tdi),
      .cap_val (cap_val),
      .sh      (ir_sh)
   );

   mdss_decode #(.ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS)) u_dec (
      .code      (ir_sh),
      .slot_addr (slot_addr),
      .grp_en    (grp_en),
      .kind      (dec_kind),
      .park      (dec_park)
   );

   assign sel_any  = sel_is_active(kind_q);
   assign sel_uniq = (kind_q == SK_UNIQUE);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         kind_q <= SK_NONE;
         park_q <= PK_NONE;
      end else if (tap_nx == TS_RESET) begin
         kind_q <= SK_NONE;
         park_q <= PK_NONE;
      end else if (tap_st == TS_UPD_IR) begin
         if (dec_park != PK_NONE) begin
            if (sel_any) begin
               park_q <= dec_park;
            end
         end else begin
            kind_q <= dec_kind;
            park_q <= PK_NONE;
         end
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         byp_q <= 1'b0;
      end else if (tap_st == TS_CAP_DR) begin
         byp_q <= 1'b0;
      end else if (tap_st == TS_SHF_DR) begin
         byp_q <= tdi;
      end
   end

   assign shift_any = (tap_st == TS_SHF_IR) || (tap_st == TS_SHF_DR);
   assign tdo_d     = (tap_st == TS_SHF_IR) ? ir_sh[0] : byp_q;
   assign oe_d      = sel_uniq && shift_any;

   generate
      if (TDO_RETIME) begin : g_tdo_neg
         logic tdo_q;
         logic oe_q;
         always_ff @(negedge tck or negedge trst_n) begin
            if (!trst_n) begin
               tdo_q <= 1'b0;
               oe_q  <= 1'b0;
            end else begin
               tdo_q <= tdo_d;
               oe_q  <= oe_d;
            end
         end
         assign tdo    = tdo_q;
         assign tdo_oe = oe_q;
      end else begin : g_tdo_comb
         assign tdo    = tdo_d;
         assign tdo_oe = oe_d;
      end
   endgenerate

   assign selected   = sel_any;
   assign shared_sel = (kind_q == SK_GROUP) || (kind_q == SK_BCAST);
   assign park_rti   = (park_q == PK_IDLE);
   assign park_pause = (park_q == PK_PAUSE);
   assign lcl_tms    = (park_q != PK_NONE) ? 1'b0 : tms;

endmodule

// File: rtl/mdss_checker.sv
module mdss_checker
   import mdss_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned NUM_GROUPS = 4
) (
   input logic              tck,
   input logic              trst_n,
   input logic              selected,
   input logic              shared_sel,
   input logic              tdo_oe,
   input logic              park_rti,
   input logic              park_pause,
   input logic [ADDR_W-1:0] slot_addr,
   input logic [ADDR_W-1:0] ir_code,
   input tap_state_e        tap_state,
   input tap_state_e        tap_nxt
);

   localparam int unsigned ALL_ONES = (1 << ADDR_W) - 1;
   localparam logic [ADDR_W-1:0] GBASE = ADDR_W'(ALL_ONES - 3 - NUM_GROUPS);

   // R7: only a unique selection may enable the backplane driver
   assert_oe_unique_R7: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe |-> (selected && !shared_sel));

   // R5, R6: a shared selection is always a selection
   assert_shared_sel_R5: assert property (@(posedge tck) disable iff (!trst_n)
      shared_sel |-> selected);

   // R9, R10: a park only exists on a selected board
   assert_park_sel_R10: assert property (@(posedge tck) disable iff (!trst_n)
      (park_rti || park_pause) |-> selected);

   // R9: the two park states exclude each other
   assert_park_excl_R9: assert property (@(posedge tck) disable iff (!trst_n)
      !(park_rti && park_pause));

   // R12: in Test-Logic-Reset nothing is selected or parked
   assert_tlr_clear_R12: assert property (@(posedge tck) disable iff (!trst_n)
      (tap_state == TS_RESET) |-> (!selected && !park_rti && !park_pause));

   // R4: the all-zero code never selects
   assert_zero_never_R4: assert property (@(posedge tck) disable iff (!trst_n)
      ((tap_state == TS_UPD_IR) && (ir_code == '0)) |=> !selected);

   // R2: matching unique code selects uniquely
   assert_unique_R2: assert property (@(posedge tck) disable iff (!trst_n)
      ((tap_state == TS_UPD_IR) && (ir_code == slot_addr) && (ir_code != '0)
       && (ir_code < GBASE)) |=> (selected && !shared_sel));

   // R11: state only moves at Update-IR or on reset entry
   assert_persist_R11: assert property (@(posedge tck) disable iff (!trst_n)
      ((tap_state != TS_UPD_IR) && (tap_nxt != TS_RESET))
      |=> ($stable(selected) && $stable(shared_sel) && $stable(park_rti)
           && $stable(park_pause)));

endmodule

bind mdrop_slot_sel mdss_checker #(.ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS)) u_chk (
   .tck        (tck),
   .trst_n     (trst_n),
   .selected   (selected),
   .shared_sel (shared_sel),
   .tdo_oe     (tdo_oe),
   .park_rti   (park_rti),
   .park_pause (park_pause),
   .slot_addr  (slot_addr),
   .ir_code    (ir_sh),
   .tap_state  (tap_st),
   .tap_nxt    (tap_nx)
);

// File: tb/mdrop_slot_sel_bench.sv
module mdrop_slot_sel_bench;

   logic       tck    = 1'b0;
   logic       trst_n = 1'b0;
   logic       tms    = 1'b1;
   logic       tdi    = 1'b0;
   logic [7:0] slot   = 8'h2A;
   logic [3:0] grp    = 4'b0101;
   logic       tdo, tdo_oe, selected, shared_sel, park_rti, park_pause, lcl_tms;

   int checks = 0;
   int errors = 0;

   mdrop_slot_sel u_mdrop_slot_sel (
      .tck        (tck),
      .trst_n     (trst_n),
      .tms        (tms),
      .tdi        (tdi),
      .slot_addr  (slot),
      .grp_en     (grp),
      .tdo        (tdo),
      .tdo_oe     (tdo_oe),
      .selected   (selected),
      .shared_sel (shared_sel),
      .park_rti   (park_rti),
      .park_pause (park_pause),
      .lcl_tms    (lcl_tms)
   );

   always #4 tck = ~tck;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d, output logic o, output logic e);
      @(negedge tck);
      #1;
      o   = tdo;
      e   = tdo_oe;
      tms = m;
      tdi = d;
   endtask

   task automatic settle();
      @(posedge tck);
      #2;
   endtask

   // from Run-Test/Idle to Run-Test/Idle through an IR scan
   task automatic shift_ir(input logic [7:0] v, output logic [7:0] out, output logic [7:0] oem);
      logic o, e;
      step(1'b1, 1'b0, o, e);
      step(1'b1, 1'b0, o, e);
      step(1'b0, 1'b0, o, e);
      step(1'b0, 1'b0, o, e);
      for (int i = 0; i < 8; i++) begin
         step(i == 7, v[i], o, e);
         out[i] = o;
         oem[i] = e;
      end
      step(1'b1, 1'b0, o, e);
      step(1'b0, 1'b0, o, e);
      settle();
   endtask

   task automatic shift_dr(input logic [3:0] v, output logic [3:0] out,
                           output logic [3:0] oem, output logic oe_after);
      logic o, e;
      step(1'b1, 1'b0, o, e);
      step(1'b0, 1'b0, o, e);
      step(1'b0, 1'b0, o, e);
      for (int i = 0; i < 4; i++) begin
         step(i == 3, v[i], o, e);
         out[i] = o;
         oem[i] = e;
      end
      step(1'b1, 1'b0, o, e);
      oe_after = e;
      step(1'b0, 1'b0, o, e);
      settle();
   endtask

   task automatic probe_lcl_tms(output logic v);
      @(negedge tck);
      #1 tms = 1'b1;
      #1 v = lcl_tms;
      tms = 1'b0;
   endtask

   task automatic sel_code(input logic [7:0] v);
      logic [7:0] o, m;
      shift_ir(v, o, m);
   endtask

   task automatic t_reset();
      logic o, e;
      trst_n = 1'b0;
      tms    = 1'b1;
      repeat (3) @(posedge tck);
      #2;
      chk("R1", "selected in reset", selected, 1'b0);
      chk("R1", "shared in reset", shared_sel, 1'b0);
      chk("R1", "oe in reset", tdo_oe, 1'b0);
      chk("R1", "park in reset", {park_rti, park_pause}, 2'b00);
      @(negedge tck);
      trst_n = 1'b1;
      step(1'b0, 1'b0, o, e);
      settle();
      chk("R1", "selected after release", selected, 1'b0);
   endtask

   task automatic t_unique();
      logic [7:0] o, m;
      shift_ir(8'h2A, o, m);
      chk("R8", "default capture value", o, 8'h01);
      chk("R2", "selected by own slot", selected, 1'b1);
      chk("R2", "unique is not shared", shared_sel, 1'b0);
      chk("R7", "oe off in idle", tdo_oe, 1'b0);
      shift_ir(8'h2A, o, m);
      chk("R7", "oe on through IR shift", m, 8'hFF);
      chk("R2", "still selected", selected, 1'b1);
   endtask

   task automatic t_mismatch();
      sel_code(8'h2A);
      sel_code(8'h2B);
      chk("R3", "other slot deselects", selected, 1'b0);
      sel_code(8'h2A);
      sel_code(8'hF9);
      chk("R3", "non-member group deselects", selected, 1'b0);
   endtask

   task automatic t_zero_and_edge();
      slot = 8'h00;
      sel_code(8'h00);
      chk("R4", "zero code with zero slot", selected, 1'b0);
      slot = 8'hF7;
      sel_code(8'hF7);
      chk("R2", "highest unique slot", {selected, shared_sel}, 2'b10);
      slot = 8'h01;
      sel_code(8'h01);
      chk("R2", "lowest unique slot", {selected, shared_sel}, 2'b10);
      slot = 8'h2A;
      sel_code(8'h00);
      chk("R4", "zero code deselects", selected, 1'b0);
   endtask

   task automatic t_bcast();
      logic [3:0] o, m;
      logic       a;
      sel_code(8'hFF);
      chk("R5", "broadcast selects shared", {selected, shared_sel}, 2'b11);
      shift_dr(4'b1101, o, m, a);
      chk("R7", "broadcast keeps oe off", m, 4'b0000);
      chk("R11", "broadcast survives DR scan", {selected, shared_sel}, 2'b11);
   endtask

   task automatic t_group();
      sel_code(8'hF8);
      chk("R6", "member group 0", {selected, shared_sel}, 2'b11);
      sel_code(8'hF9);
      chk("R6", "non-member group 1", {selected, shared_sel}, 2'b00);
      sel_code(8'hFA);
      chk("R6", "member group 2", {selected, shared_sel}, 2'b11);
      sel_code(8'hFB);
      chk("R6", "non-member group 3", {selected, shared_sel}, 2'b00);
   endtask

   task automatic t_bypass();
      logic [3:0] o, m;
      logic       a;
      sel_code(8'h2A);
      shift_dr(4'b1101, o, m, a);
      chk("R7", "bypass data", o, 4'b1010);
      chk("R7", "oe on in DR shift", m, 4'b1111);
      chk("R7", "oe off after shift", a, 1'b0);
      shift_dr(4'b0110, o, m, a);
      chk("R7", "bypass second pattern", o, 4'b1100);
      chk("R11", "unique survives DR scans", {selected, shared_sel}, 2'b10);
   endtask

   task automatic t_interrog();
      logic [7:0] o, m;
      sel_code(8'hFE);
      chk("R8", "interrogation not selected", {selected, shared_sel}, 2'b00);
      shift_ir(8'h00, o, m);
      chk("R8", "slot address captured", o, 8'h2A);
      chk("R7", "oe off while unselected", m, 8'h00);
      shift_ir(8'h2A, o, m);
      chk("R8", "capture back to default", o, 8'h01);
      slot = 8'h5C;
      sel_code(8'hFE);
      shift_ir(8'h00, o, m);
      chk("R8", "second slot captured", o, 8'h5C);
      slot = 8'h2A;
   endtask

   task automatic t_park();
      logic v;
      sel_code(8'h2A);
      probe_lcl_tms(v);
      chk("R9", "lcl_tms follows when unparked", v, 1'b1);
      sel_code(8'hFC);
      chk("R9", "park idle flags", {park_rti, park_pause}, 2'b10);
      chk("R9", "park keeps selection", {selected, shared_sel}, 2'b10);
      probe_lcl_tms(v);
      chk("R9", "lcl_tms held low", v, 1'b0);
      sel_code(8'hFD);
      chk("R9", "park pause flags", {park_rti, park_pause}, 2'b01);
      sel_code(8'h2A);
      chk("R9", "non-park code unparks", {park_rti, park_pause, selected}, 3'b001);
      sel_code(8'h2B);
      sel_code(8'hFC);
      chk("R10", "park ignored when unselected", {park_rti, park_pause, selected}, 3'b000);
      probe_lcl_tms(v);
      chk("R10", "lcl_tms untouched when unselected", v, 1'b1);
   endtask

   task automatic t_tlr();
      logic o, e;
      sel_code(8'h2A);
      sel_code(8'hFD);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, e);
      settle();
      chk("R12", "five TMS high clears", {selected, park_rti, park_pause}, 3'b000);
      step(1'b0, 1'b0, o, e);
      settle();
      sel_code(8'hFF);
      @(negedge tck);
      trst_n = 1'b0;
      #2;
      chk("R12", "trst clears broadcast", {selected, shared_sel}, 2'b00);
      @(negedge tck);
      trst_n = 1'b1;
      step(1'b0, 1'b0, o, e);
      settle();
   endtask

   initial begin : watchdog
      #(8 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      t_reset();
      t_unique();
      t_mismatch();
      t_zero_and_edge();
      t_bcast();
      t_group();
      t_bypass();
      t_interrog();
      t_park();
      t_tlr();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule